// File: doc/BRIEF.md
# Sectioned Multiply-Accumulate Unit with Preload

The unit multiplies two 16-bit operands and gives a 32-bit product. A mode input selects how both operands are read: as signed two's-complement values or as unsigned magnitudes. The product can be rounded to 16-bit precision. The product is then either written into a 35-bit accumulator, added to it, or used as the minuend with the accumulator as the subtrahend. The accumulator is split into three sections: a 3-bit extension (bits 34..32), an upper half (bits 31..16) and a lower half (bits 15..0). Each section has its own output-drive enable. A section whose output is disabled can be loaded directly from its own pins while preload is asserted.

Everything runs in one clock domain. The three strobes are single-cycle enables:
- `a_stb` captures operand A.
- `b_stb` captures operand B.
- Either operand strobe also captures the control inputs.
- `r_stb` updates the accumulator.

The strobes are the only flow control, and there is no back-pressure: every strobe is accepted in the cycle it is high. The shared pins are split into separate input, output and drive-enable ports. The lower-half preload value arrives on the operand B bus, because those pins are shared.

Top module: `mac16_preload`

## Requirements
- R1: `a_i` is captured only at a clock edge with `a_stb` high, and `b_i` only at an edge with `b_stb` high. Operand values present at other edges have no effect on later results.
- R2: `tc_i`, `rnd_i`, `acc_i` and `sub_i` are captured at an edge where `a_stb` or `b_stb` is high. At other edges they have no effect.
- R3: With the captured `tc_i` = 1, both operands are two's complement, and the product is sign-extended to 35 bits.
- R4: With the captured `tc_i` = 0, both operands are unsigned, and the product is zero-extended to 35 bits.
- R5: With the captured `rnd_i` = 1, the value 0x8000 (a 1 at bit 15) is added to the extended product before it is used.
- R6: The operation depends on the captured (`acc_i`, `sub_i`) pair. (1,0) stores accumulator + product. (1,1) stores product − accumulator. (0,0) stores the product. All results are modulo 2^35. The pair (0,1) is unspecified.
- R7: The accumulator changes only at an edge where `r_stb` is high.
- R8: With `prel_i` = 1 at an `r_stb` edge, each section whose disable input is 1 loads its pins:
  - the extension section loads `ext_pin_i[2:0]` into bits 34..32;
  - the upper section loads `hi_pin_i` into bits 31..16;
  - the lower section loads `b_i` into bits 15..0.
- R9: With `prel_i` = 1 at an `r_stb` edge, each section whose disable input is 0 keeps its value.
- R10: Each `*_drv_o` equals the inverse of its `*_dis_i` input. `ext_o`, `hi_o` and `lo_o` always show the section contents. With `prel_i` = 0, all sections take the arithmetic result whatever the disable inputs are.
- R11: While `rst_n` is low, the accumulator, the operands and the captured controls are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_stb | input | 1 | Operand A capture strobe |
| b_stb | input | 1 | Operand B capture strobe |
| r_stb | input | 1 | Accumulator update strobe |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B; also the lower-section preload value |
| tc_i | input | 1 | 1 = two's complement, 0 = unsigned |
| rnd_i | input | 1 | Round the product at bit 15 |
| acc_i | input | 1 | Accumulate select |
| sub_i | input | 1 | Reverse-subtract select |
| prel_i | input | 1 | Preload mode |
| ext_dis_i | input | 1 | Extension section output disable |
| hi_dis_i | input | 1 | Upper section output disable |
| lo_dis_i | input | 1 | Lower section output disable |
| ext_pin_i | input | 3 | Extension section pin input |
| hi_pin_i | input | 16 | Upper section pin input |
| ext_o | output | 3 | Accumulator bits 34..32 |
| hi_o | output | 16 | Accumulator bits 31..16 |
| lo_o | output | 16 | Accumulator bits 15..0 |
| ext_drv_o | output | 1 | Extension section pin drive enable |
| hi_drv_o | output | 1 | Upper section pin drive enable |
| lo_drv_o | output | 1 | Lower section pin drive enable |

## Verification
Operands and controls are registered at the edge of their strobe. Their product reaches the accumulator at the first later edge with `r_stb` high. An `r_stb` in the same edge as an operand strobe therefore uses the operands captured before that edge.

Accumulator outputs change exactly one register after the `r_stb` edge. The drive enables follow their disable inputs in the same cycle.

The bench keeps its own model registers and updates them at each edge in the same order. It compares every section and every drive enable 1 ns after each edge. Directed steps also compare against constants worked out by hand.

// File: rtl/mac16_pkg.sv
package mac16_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD = 2'd0,
    ACC_ADD  = 2'd1,
    ACC_RSUB = 2'd2
  } acc_op_e;

  typedef struct packed {
    logic    tc;
    logic    rnd;
    acc_op_e op;
  } mac_ctrl_t;

  // The (acc=0, sub=1) pair is unspecified; it decodes as a direct load.
  function automatic acc_op_e decode_op(input logic acc, input logic sub);
    if (acc && sub) return ACC_RSUB;
    else if (acc)   return ACC_ADD;
    else            return ACC_LOAD;
  endfunction

endpackage

// File: rtl/mac16_capture.sv
module mac16_capture
  import mac16_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            a_stb,
  input  logic            b_stb,
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  input  logic            tc_i,
  input  logic            rnd_i,
  input  logic            acc_i,
  input  logic            sub_i,
  output logic [OP_W-1:0] a_q,
  output logic [OP_W-1:0] b_q,
  output mac_ctrl_t       ctrl_q
);

  logic ctrl_en;
  assign ctrl_en = a_stb | b_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
    end else if (a_stb) begin
      a_q <= a_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q <= '0;
    end else if (b_stb) begin
      b_q <= b_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{tc: 1'b0, rnd: 1'b0, op: ACC_LOAD};
    end else if (ctrl_en) begin
      ctrl_q <= '{tc: tc_i, rnd: rnd_i, op: decode_op(acc_i, sub_i)};
    end
  end

endmodule

// File: rtl/mac16_product.sv
module mac16_product #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 35
) (
  input  logic [OP_W-1:0]  a,
  input  logic [OP_W-1:0]  b,
  input  logic             tc,
  input  logic             rnd,
  output logic [ACC_W-1:0] prod
);

  // One signed multiplier serves both modes: each operand gets one extra
  // top bit, set from its sign only in two's-complement mode.
  localparam int XW  = OP_W + 1;
  localparam int PW  = 2 * XW;
  localparam int PAD = ACC_W - PW;
  localparam logic [ACC_W-1:0] RND_ADD = ACC_W'(1) << (OP_W - 1);

  logic signed [XW-1:0] ax;
  logic signed [XW-1:0] bx;
  logic signed [PW-1:0] p;
  logic [ACC_W-1:0]     p_ext;

  always_comb begin
    ax    = $signed({tc & a[OP_W-1], a});
    bx    = $signed({tc & b[OP_W-1], b});
    p     = ax * bx;
    // Unsigned products are never negative, so extending the sign bit
    // gives zero extension in that mode.
    p_ext = {{PAD{p[PW-1]}}, p};
    prod  = p_ext + (rnd ? RND_ADD : '0);
  end

endmodule

// File: rtl/mac16_acc_section.sv
module mac16_acc_section #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= '0;
    end else if (load_i) begin
      q_o <= d_i;
    end
  end

endmodule

// File: rtl/mac16_preload.sv
module mac16_preload
  import mac16_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int EXT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_stb,
  input  logic             b_stb,
  input  logic             r_stb,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  input  logic             tc_i,
  input  logic             rnd_i,
  input  logic             acc_i,
  input  logic             sub_i,
  input  logic             prel_i,
  input  logic             ext_dis_i,
  input  logic             hi_dis_i,
  input  logic             lo_dis_i,
  input  logic [EXT_W-1:0] ext_pin_i,
  input  logic [OP_W-1:0]  hi_pin_i,
  output logic [EXT_W-1:0] ext_o,
  output logic [OP_W-1:0]  hi_o,
  output logic [OP_W-1:0]  lo_o,
  output logic             ext_drv_o,
  output logic             hi_drv_o,
  output logic             lo_drv_o
);

  localparam int PROD_W = 2 * OP_W;
  localparam int ACC_W  = PROD_W + EXT_W;
  localparam int N_SEC  = 3;

  logic [OP_W-1:0]  a_q;
  logic [OP_W-1:0]  b_q;
  mac_ctrl_t        ctrl_q;
  logic [ACC_W-1:0] prod;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] arith;
  logic [ACC_W-1:0] pre_vec;
  logic [N_SEC-1:0] sec_dis;

  mac16_capture #(.OP_W(OP_W)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_stb  (a_stb),
    .b_stb  (b_stb),
    .a_i    (a_i),
    .b_i    (b_i),
    .tc_i   (tc_i),
    .rnd_i  (rnd_i),
    .acc_i  (acc_i),
    .sub_i  (sub_i),
    .a_q    (a_q),
    .b_q    (b_q),
    .ctrl_q (ctrl_q)
  );

  mac16_product #(.OP_W(OP_W), .ACC_W(ACC_W)) u_product (
    .a    (a_q),
    .b    (b_q),
    .tc   (ctrl_q.tc),
    .rnd  (ctrl_q.rnd),
    .prod (prod)
  );

  always_comb begin
    unique case (ctrl_q.op)
      ACC_ADD:  arith = acc_q + prod;
      ACC_RSUB: arith = prod - acc_q;
      default:  arith = prod;
    endcase
  end

  assign pre_vec = {ext_pin_i, hi_pin_i, b_i};
  assign sec_dis = {ext_dis_i, hi_dis_i, lo_dis_i};

  // Section g: 0 = lower half, 1 = upper half, 2 = extension.
  for (genvar g = 0; g < N_SEC; g++) begin : g_sec
    localparam int LSB = (g == 0) ? 0 : (g == 1) ? OP_W : PROD_W;
    localparam int W   = (g == 2) ? EXT_W : OP_W;

    logic         load;
    logic [W-1:0] d;

    always_comb begin
      load = r_stb & (~prel_i | sec_dis[g]);
      d    = prel_i ? pre_vec[LSB +: W] : arith[LSB +: W];
    end

    mac16_acc_section #(.W(W)) u_sec (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .d_i    (d),
      .q_o    (acc_q[LSB +: W])
    );
  end

  assign ext_o     = acc_q[ACC_W-1:PROD_W];
  assign hi_o      = acc_q[PROD_W-1:OP_W];
  assign lo_o      = acc_q[OP_W-1:0];
  assign ext_drv_o = ~ext_dis_i;
  assign hi_drv_o  = ~hi_dis_i;
  assign lo_drv_o  = ~lo_dis_i;

endmodule

// File: rtl/mac16_preload_chk.sv
module mac16_preload_chk #(
  parameter int OP_W  = 16,
  parameter int EXT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             r_stb,
  input logic             prel_i,
  input logic             ext_dis_i,
  input logic             hi_dis_i,
  input logic             lo_dis_i,
  input logic [EXT_W-1:0] ext_pin_i,
  input logic [OP_W-1:0]  hi_pin_i,
  input logic [OP_W-1:0]  b_i,
  input logic [EXT_W-1:0] ext_o,
  input logic [OP_W-1:0]  hi_o,
  input logic [OP_W-1:0]  lo_o
);

  // R7
  acc_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !r_stb |=> $stable({ext_o, hi_o, lo_o}));

  // R8
  ext_preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_stb && prel_i && ext_dis_i) |=> ext_o == $past(ext_pin_i));

  // R8
  hi_preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_stb && prel_i && hi_dis_i) |=> hi_o == $past(hi_pin_i));

  // R8
  lo_preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_stb && prel_i && lo_dis_i) |=> lo_o == $past(b_i));

  // R9
  hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_stb && prel_i && !hi_dis_i) |=> $stable(hi_o));

  // R9
  lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_stb && prel_i && !lo_dis_i) |=> $stable(lo_o));

endmodule

bind mac16_preload mac16_preload_chk #(.OP_W(OP_W), .EXT_W(EXT_W)) u_chk (.*);

// File: tb/mac16_preload_test.sv
module mac16_preload_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_stb = 0, b_stb = 0, r_stb = 0;
  logic [15:0] a_i = '0, b_i = '0, hi_pin_i = '0;
  logic        tc_i = 0, rnd_i = 0, acc_i = 0, sub_i = 0, prel_i = 0;
  logic        ext_dis_i = 0, hi_dis_i = 0, lo_dis_i = 0;
  logic [2:0]  ext_pin_i = '0;
  logic [2:0]  ext_o;
  logic [15:0] hi_o, lo_o;
  logic        ext_drv_o, hi_drv_o, lo_drv_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model state
  logic [15:0] m_a = '0, m_b = '0;
  logic        m_tc = 0, m_rnd = 0, m_acc = 0, m_sub = 0;
  logic [34:0] m_r = '0;

  always #5 clk = ~clk;

  mac16_preload uut (.*);

  function automatic logic [34:0] ref_prod(logic [15:0] a, logic [15:0] b,
                                           logic tc, logic rnd);
    longint sa = tc ? longint'($signed(a)) : longint'(a);
    longint sb = tc ? longint'($signed(b)) : longint'(b);
    longint p  = sa * sb + (rnd ? 64'sd32768 : 64'sd0);
    return p[34:0];
  endfunction

  function automatic logic [34:0] ref_arith(logic [34:0] r, logic [34:0] p,
                                            logic acc, logic sub);
    if (acc && sub) return p - r;
    if (acc)        return r + p;
    return p;
  endfunction

  task automatic check(string tag, logic [34:0] act, logic [34:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [34:0] dut_r();
    return {ext_o, hi_o, lo_o};
  endfunction

  // One clock edge: update the model as the requirements say, then compare.
  task automatic tick(string tag);
    logic [34:0] ar;
    @(posedge clk);
    ar = ref_arith(m_r, ref_prod(m_a, m_b, m_tc, m_rnd), m_acc, m_sub);
    if (r_stb) begin
      if (!prel_i)        m_r = ar;
      else begin
        if (ext_dis_i)    m_r[34:32] = ext_pin_i;
        if (hi_dis_i)     m_r[31:16] = hi_pin_i;
        if (lo_dis_i)     m_r[15:0]  = b_i;
      end
    end
    if (a_stb) m_a = a_i;
    if (b_stb) m_b = b_i;
    if (a_stb || b_stb) begin
      m_tc = tc_i; m_rnd = rnd_i; m_acc = acc_i; m_sub = sub_i;
    end
    #1;
    check(tag, dut_r(), m_r);
    check("R10", 35'({ext_drv_o, hi_drv_o, lo_drv_o}),
          35'({~ext_dis_i, ~hi_dis_i, ~lo_dis_i}));
  endtask

  task automatic load_ops(logic [15:0] a, logic [15:0] b, logic tc,
                          logic rnd, logic acc, logic sub);
    a_i = a; b_i = b; tc_i = tc; rnd_i = rnd; acc_i = acc; sub_i = sub;
    a_stb = 1; b_stb = 1; r_stb = 0;
    tick("R1/R2");
    a_stb = 0; b_stb = 0;
  endtask

  task automatic fire(string tag);
    r_stb = 1;
    tick(tag);
    r_stb = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    check("R11", dut_r(), 35'h0);
    rst_n = 1;
    tick("R11");

    // R3: signed corner cases
    load_ops(16'h8000, 16'h8000, 1, 0, 0, 0);
    fire("R3");
    check("R3", dut_r(), 35'h0_4000_0000);
    load_ops(16'hFFFF, 16'h0003, 1, 0, 0, 0);
    fire("R3");
    check("R3", dut_r(), 35'h7_FFFF_FFFD);

    // R4, R5: unsigned maximum, rounded
    load_ops(16'hFFFF, 16'hFFFF, 0, 1, 0, 0);
    fire("R4/R5");
    check("R5", dut_r(), 35'h0_FFFE_8001);

    // R6: add, then reverse subtract
    load_ops(16'h0002, 16'h0003, 0, 0, 1, 0);
    fire("R6");
    check("R6", dut_r(), 35'h0_FFFE_8007);
    load_ops(16'h0001, 16'h0001, 0, 0, 1, 1);
    fire("R6");
    check("R6", dut_r(), 35'h7_0001_7FFA);

    // R1, R2: only A strobed, then input changes with no strobe
    a_i = 16'h0010; acc_i = 0; sub_i = 0; a_stb = 1;
    tick("R1");
    a_stb = 0;
    a_i = 16'h7777; b_i = 16'h5555; tc_i = 1; acc_i = 1;
    fire("R1/R2");
    check("R1", dut_r(), 35'h0_0000_0010);

    // R8, R9: preload two sections, keep the enabled one
    acc_i = 0;
    prel_i = 1; ext_dis_i = 1; hi_dis_i = 1; lo_dis_i = 0;
    ext_pin_i = 3'h5; hi_pin_i = 16'hABCD; b_i = 16'h1234;
    fire("R8/R9");
    check("R9", dut_r(), 35'h5_ABCD_0010);
    ext_dis_i = 0; hi_dis_i = 0; lo_dis_i = 1; b_i = 16'hBEEF;
    ext_pin_i = 3'h2; hi_pin_i = 16'h0000;
    fire("R8/R9");
    check("R8", dut_r(), 35'h5_ABCD_BEEF);

    // R10: disabled outputs still take the arithmetic result
    prel_i = 0; ext_dis_i = 1; hi_dis_i = 1; lo_dis_i = 1;
    fire("R10");
    check("R10", dut_r(), 35'h0_0000_0010);

    // R7: no r_stb leaves the accumulator alone
    load_ops(16'h1234, 16'h4321, 1, 1, 1, 0);
    tick("R7");
    check("R7", dut_r(), 35'h0_0000_0010);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      a_stb = 1'($urandom); b_stb = 1'($urandom); r_stb = 1'($urandom);
      a_i = 16'($urandom); b_i = 16'($urandom); hi_pin_i = 16'($urandom);
      ext_pin_i = 3'($urandom);
      tc_i = 1'($urandom); rnd_i = 1'($urandom);
      acc_i = 1'($urandom); sub_i = 1'($urandom);
      if (!acc_i) sub_i = 0;
      prel_i = ($urandom % 8) == 0;
      ext_dis_i = 1'($urandom); hi_dis_i = 1'($urandom); lo_dis_i = 1'($urandom);
      tick("R1/R2/R3/R4/R5/R6/R7/R8/R9");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule